// File: doc/BRIEF.md
# Lambda-Min Check Node Processor

This block produces the check-to-variable messages of a single parity check in a low-density parity-check decoder. It uses the min-based approximation of log-domain belief propagation with three retained minima. Up to `DEG` variable-to-check messages arrive together, each as a 5-bit sign-magnitude word, with an enable bit for each edge. One cycle-aligned vector of outgoing messages leaves three clock edges later, in the same format.

The sign of each outgoing message is the parity of the signs on all other enabled edges. For the magnitude, the three smallest incoming magnitudes across the whole check are found once. Each edge then adds the transfer-table values of the minima that are not its own edge. The sum saturates and passes through the same table again, because the function -log tanh(x/2) is its own inverse. The block accepts a new vector on every cycle. Scheduling, message storage and the routing network sit outside it.

Top module: `lambda_min_cnp`

## Requirements
- R1: Edge e occupies bits [5e+4:5e] of `in_msg` and `out_msg`. Bit 5e+4 is the sign (1 means negative), and bits [5e+3:5e] are the unsigned magnitude.
- R2: A vector accepted with `in_valid` high produces `out_valid` high, with its results on `out_msg`, exactly 3 clock edges later. Idle input cycles give `out_valid` low 3 edges later.
- R3: While reset is held and after it is released, `out_valid` and `out_msg` are zero until a valid vector has propagated.
- R4: The output sign of an enabled edge is the XOR of the signs of all other enabled edges.
- R5: The transfer table, indexed by magnitude 0..15, holds 15, 3, 2, 1, 1, and then 0 for every magnitude from 5 to 15.
- R6: The three minima are the three smallest effective magnitudes. When magnitudes are equal, the lower edge index ranks first.
- R7: For an enabled edge that is one of the three minima, the output magnitude is table(min(15, sum of table values of the other two minima)).
- R8: For an enabled edge that is not one of the three minima, the output magnitude is table(min(15, sum of table values of all three minima)).
- R9: The sum of table values saturates at 15 before the second lookup.
- R10: A disabled edge counts as magnitude 15 with a positive sign for every other edge. Its own output word is all zero.
- R11: Vectors presented on consecutive cycles are processed independently, with no interaction between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input vector qualifier |
| in_msg | input | 5*DEG | Incoming variable-to-check messages, packed per R1 |
| in_en | input | DEG | Edge enable mask, bit e for edge e |
| out_valid | output | 1 | Output vector qualifier |
| out_msg | output | 5*DEG | Outgoing check-to-variable messages, packed per R1 |

## Verification
A four-edge instance is swept through every combination of the four magnitudes. Each vector also carries a sign pattern that varies with the vector count.

Most vectors enable all edges. This exercises the choice between excluding one of the three minima and using all three, including the low-index rule on ties. One vector in five uses a partial mask, which separates correct treatment of disabled edges from a design that leaks their signs or magnitudes.

The vectors stream back to back, with occasional idle cycles. This shows that the pipeline keeps neighbouring vectors apart and that the valid flag tracks the data.

// File: rtl/lmin_cnp_pkg.sv
package lmin_cnp_pkg;
  localparam int MAG_W = 4;
  localparam int MSG_W = MAG_W + 1;
  localparam int MAG_MAX = (1 << MAG_W) - 1;

  typedef logic [MAG_W-1:0] mag_t;

  // Transfer function -log tanh(x/2), half-unit fixed point (R5)
  function automatic mag_t phi_lut(input mag_t x);
    mag_t r;
    case (x)
      4'd0:       r = 4'd15;
      4'd1:       r = 4'd3;
      4'd2:       r = 4'd2;
      4'd3, 4'd4: r = 4'd1;
      default:    r = 4'd0;
    endcase
    return r;
  endfunction

  // Saturating addition of up to three table values (R9)
  function automatic mag_t phi_sum_sat(input mag_t a, input mag_t b,
                                       input mag_t c, input logic use_c);
    logic [MAG_W+1:0] s;
    s = {2'b00, a} + {2'b00, b} + (use_c ? {2'b00, c} : '0);
    return (s > MAG_MAX) ? mag_t'(MAG_MAX) : s[MAG_W-1:0];
  endfunction
endpackage

// File: rtl/lmin_min3_finder.sv
module lmin_min3_finder
  import lmin_cnp_pkg::*;
#(
  parameter int DEG = 20,
  parameter int IW  = (DEG > 1) ? $clog2(DEG) : 1
) (
  input  logic [DEG*MAG_W-1:0] mags,
  output mag_t                 m1,
  output mag_t                 m2,
  output mag_t                 m3,
  output logic [IW-1:0]        i1,
  output logic [IW-1:0]        i2,
  output logic [IW-1:0]        i3
);
  logic [MAG_W:0]  a, b, c, v;
  logic [IW-1:0]   ia, ib, ic;

  // Insertion scan; strict compare keeps the lower index ahead on ties (R6)
  always_comb begin
    a = {1'b1, {MAG_W{1'b0}}};
    b = a;
    c = a;
    ia = '0;
    ib = '0;
    ic = '0;
    v = '0;
    for (int e = 0; e < DEG; e++) begin
      v = {1'b0, mags[e*MAG_W +: MAG_W]};
      if (v < a) begin
        c = b; ic = ib;
        b = a; ib = ia;
        a = v; ia = IW'(e);
      end else if (v < b) begin
        c = b; ic = ib;
        b = v; ib = IW'(e);
      end else if (v < c) begin
        c = v; ic = IW'(e);
      end
    end
    m1 = a[MAG_W-1:0];
    m2 = b[MAG_W-1:0];
    m3 = c[MAG_W-1:0];
    i1 = ia;
    i2 = ib;
    i3 = ic;
  end
endmodule

// File: rtl/lmin_edge_out.sv
module lmin_edge_out
  import lmin_cnp_pkg::*;
#(
  parameter int IW   = 5,
  parameter int EDGE = 0
) (
  input  mag_t             m1,
  input  mag_t             m2,
  input  mag_t             m3,
  input  logic [IW-1:0]    i1,
  input  logic [IW-1:0]    i2,
  input  logic [IW-1:0]    i3,
  input  logic             parity,
  input  logic             own_sign,
  input  logic             en,
  output logic [MSG_W-1:0] msg
);
  localparam logic [IW-1:0] ME = IW'(EDGE);

  mag_t sum_sat;
  mag_t mag;
  logic sgn;

  always_comb begin
    if (ME == i1)      sum_sat = phi_sum_sat(phi_lut(m2), phi_lut(m3), '0, 1'b0); // R7
    else if (ME == i2) sum_sat = phi_sum_sat(phi_lut(m1), phi_lut(m3), '0, 1'b0); // R7
    else if (ME == i3) sum_sat = phi_sum_sat(phi_lut(m1), phi_lut(m2), '0, 1'b0); // R7
    else               sum_sat = phi_sum_sat(phi_lut(m1), phi_lut(m2), phi_lut(m3), 1'b1); // R8
    mag = phi_lut(sum_sat);
    sgn = parity ^ own_sign;                                   // R4
    msg = en ? {sgn, mag} : '0;                                // R10
  end
endmodule

// File: rtl/lambda_min_cnp.sv
module lambda_min_cnp
  import lmin_cnp_pkg::*;
#(
  parameter int DEG = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 in_valid,
  input  logic [DEG*MSG_W-1:0] in_msg,
  input  logic [DEG-1:0]       in_en,
  output logic                 out_valid,
  output logic [DEG*MSG_W-1:0] out_msg
);
  localparam int IW = (DEG > 1) ? $clog2(DEG) : 1;
  localparam int MV = DEG * MAG_W;
  localparam int OW = DEG * MSG_W;

  // Stage 1: masked inputs
  logic [MV-1:0]  s1_mag_d, s1_mag;
  logic [DEG-1:0] s1_sgn_d, s1_sgn, s1_en;
  logic           s1_valid;

  for (genvar e = 0; e < DEG; e++) begin : g_mask
    // Disabled edge: largest magnitude, positive sign (R10)
    assign s1_mag_d[e*MAG_W +: MAG_W] = in_en[e] ? in_msg[e*MSG_W +: MAG_W] : mag_t'(MAG_MAX);
    assign s1_sgn_d[e] = in_en[e] & in_msg[e*MSG_W + MAG_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s1_valid <= 1'b0;
      s1_mag   <= '0;
      s1_sgn   <= '0;
      s1_en    <= '0;
    end else begin
      s1_valid <= in_valid;
      s1_mag   <= s1_mag_d;
      s1_sgn   <= s1_sgn_d;
      s1_en    <= in_en;
    end
  end

  // Stage 2: global minima and sign parity
  mag_t          f_m1, f_m2, f_m3;
  logic [IW-1:0] f_i1, f_i2, f_i3;
  logic          f_parity;

  lmin_min3_finder #(.DEG(DEG), .IW(IW)) u_min3 (
    .mags (s1_mag),
    .m1   (f_m1),
    .m2   (f_m2),
    .m3   (f_m3),
    .i1   (f_i1),
    .i2   (f_i2),
    .i3   (f_i3)
  );

  assign f_parity = ^s1_sgn;

  mag_t           s2_m1, s2_m2, s2_m3;
  logic [IW-1:0]  s2_i1, s2_i2, s2_i3;
  logic           s2_parity, s2_valid;
  logic [DEG-1:0] s2_sgn, s2_en;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      s2_valid  <= 1'b0;
      s2_m1     <= '0;
      s2_m2     <= '0;
      s2_m3     <= '0;
      s2_i1     <= '0;
      s2_i2     <= '0;
      s2_i3     <= '0;
      s2_parity <= 1'b0;
      s2_sgn    <= '0;
      s2_en     <= '0;
    end else begin
      s2_valid  <= s1_valid;
      s2_m1     <= f_m1;
      s2_m2     <= f_m2;
      s2_m3     <= f_m3;
      s2_i1     <= f_i1;
      s2_i2     <= f_i2;
      s2_i3     <= f_i3;
      s2_parity <= f_parity;
      s2_sgn    <= s1_sgn;
      s2_en     <= s1_en;
    end
  end

  // Stage 3: per-edge extrinsic messages
  logic [OW-1:0] out_d;

  for (genvar e = 0; e < DEG; e++) begin : g_edge
    lmin_edge_out #(.IW(IW), .EDGE(e)) u_edge (
      .m1       (s2_m1),
      .m2       (s2_m2),
      .m3       (s2_m3),
      .i1       (s2_i1),
      .i2       (s2_i2),
      .i3       (s2_i3),
      .parity   (s2_parity),
      .own_sign (s2_sgn[e]),
      .en       (s2_en[e]),
      .msg      (out_d[e*MSG_W +: MSG_W])
    );
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_msg   <= '0;
    end else begin
      out_valid <= s2_valid;
      out_msg   <= out_d;
    end
  end

  // Observation wires for assertions
  logic [DEG-1:0] out_nz;
  for (genvar e = 0; e < DEG; e++) begin : g_nz
    assign out_nz[e] = |out_msg[e*MSG_W +: MSG_W];
  end

  AST_VALID_S1: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> s1_valid); // R2
  AST_VALID_S2: assert property (@(posedge clk) disable iff (!rst_n)
    s1_valid |=> s2_valid); // R2
  AST_VALID_OUT: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid == $past(s1_valid) |=> out_valid == $past(s2_valid)); // R11
  AST_MIN_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> (s2_m1 <= s2_m2) && (s2_m2 <= s2_m3)); // R6
  AST_MIN_DISTINCT: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |-> (s2_i1 != s2_i2) && (s2_i2 != s2_i3) && (s2_i1 != s2_i3)); // R6
  AST_DISABLED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    s2_valid |=> ((out_nz & ~$past(s2_en)) == '0)); // R10
endmodule

// File: tb/lambda_min_cnp_bench.sv
module lambda_min_cnp_bench;
  localparam int D  = 4;
  localparam int OW = D * 5;
  localparam int NV = 65536;

  // Independent copy of the transfer table from R5
  localparam int PHI_T [16] = '{15, 3, 2, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0};

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [OW-1:0] in_msg = '0;
  logic [D-1:0]  in_en = '0;
  logic          out_valid;
  logic [OW-1:0] out_msg;

  int n_vec = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  lambda_min_cnp #(.DEG(D)) u_lambda_min_cnp (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_msg    (in_msg),
    .in_en     (in_en),
    .out_valid (out_valid),
    .out_msg   (out_msg)
  );

  // Reference: sort (magnitude, index) keys, drop own edge, sum, saturate, look up
  function automatic logic [OW-1:0] ref_model(input logic [OW-1:0] msg, input logic [D-1:0] en);
    int mg [D];
    int sg [D];
    int sel [3];
    bit taken [D];
    int par, key, best, bk, sum;
    logic [OW-1:0] r;
    r = '0;
    par = 0;
    for (int e = 0; e < D; e++) begin
      mg[e] = en[e] ? int'(msg[e*5 +: 4]) : 15;          // R10
      sg[e] = en[e] ? int'(msg[e*5 + 4]) : 0;            // R1
      par ^= sg[e];
      taken[e] = 1'b0;
    end
    for (int k = 0; k < 3; k++) begin                     // R6
      best = -1; bk = 1 << 30;
      for (int e = 0; e < D; e++) begin
        key = mg[e] * 64 + e;
        if (!taken[e] && key < bk) begin bk = key; best = e; end
      end
      sel[k] = best;
      taken[best] = 1'b1;
    end
    for (int e = 0; e < D; e++) begin
      if (en[e]) begin
        sum = 0;
        for (int k = 0; k < 3; k++)
          if (sel[k] != e) sum += PHI_T[mg[sel[k]]];     // R7 R8
        if (sum > 15) sum = 15;                           // R9
        r[e*5 +: 4] = 4'(PHI_T[sum]);
        r[e*5 + 4]  = 1'(par ^ sg[e]);                    // R4
      end
    end
    return r;
  endfunction

  task automatic check_out(input logic ev, input logic [OW-1:0] em);
    n_vec++;
    if (out_valid !== ev) begin
      n_bad++;
      $display("FAIL R2 out_valid actual %0b expected %0b", out_valid, ev);
    end else if (ev && out_msg !== em) begin
      n_bad++;
      for (int e = 0; e < D; e++)
        if (out_msg[e*5 +: 5] !== em[e*5 +: 5])
          $display("FAIL %s edge %0d actual %h expected %h",
                   (out_msg[e*5+4] !== em[e*5+4]) ? "R4" : "R7/R8", e,
                   out_msg[e*5 +: 5], em[e*5 +: 5]);
    end
  endtask

  logic [OW-1:0] exp_msg [4];
  logic          exp_v   [4];

  initial begin
    for (int i = 0; i < 4; i++) begin exp_msg[i] = '0; exp_v[i] = 1'b0; end
    repeat (3) @(negedge clk);
    // R3: reset state
    n_vec++;
    if (out_valid !== 1'b0 || out_msg !== '0) begin
      n_bad++;
      $display("FAIL R3 reset actual %0b/%h expected 0/0", out_valid, out_msg);
    end
    rst_n = 1'b1;
    @(negedge clk);
    n_vec++;
    if (out_valid !== 1'b0 || out_msg !== '0) begin
      n_bad++;
      $display("FAIL R3 after reset actual %0b/%h expected 0/0", out_valid, out_msg);
    end
    // R11: back-to-back stream, idle gaps exercise R2
    for (int t = 0; t < NV + 3; t++) begin
      if (t >= 3) check_out(exp_v[(t-3) % 4], exp_msg[(t-3) % 4]);
      if (t < NV) begin
        logic [D-1:0] sgn;
        logic [D-1:0] en;
        sgn = 4'(t ^ (t >> 5) ^ (t >> 11));
        en  = (t % 5 == 0) ? 4'(t >> 2) : 4'hF;
        for (int e = 0; e < D; e++)
          in_msg[e*5 +: 5] = {sgn[e], 4'(t >> (4*e))};
        in_en    = en;
        in_valid = (t % 97 != 50);
        exp_v[t % 4]   = in_valid;
        exp_msg[t % 4] = ref_model(in_msg, en);
      end else begin
        in_valid = 1'b0;
      end
      @(negedge clk);
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    #(20 * 190000);
    n_bad++;
    $display("FAIL watchdog expired actual running expected done");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule